// File: doc/BRIEF.md
# Reset-Hold Duration Counter

This block measures how long an active-low system reset line stays asserted. While the line is low, a counter advances once per cycle of a fixed reference clock (25 MHz by default, 40 ns per count). The counter saturates at its all-ones value instead of wrapping. With the default 29-bit width, the longest hold it can measure is about 21.4 seconds. Firmware reads the count through a single 32-bit register. One second of hold equals 25,000,000 counts, so firmware can tell a short press from a long one by comparing the count against a seconds threshold.

The measured line is asynchronous to the reference clock. It passes through a two-flop synchroniser before it gates counting. A separate power-on reset is the only reset of the block's state. The line being measured never clears the count, so the value is still there for software after the line is released. Software clears the count by writing a 1 to bit 31 of the register.

Top module: `rst_hold_meter`

## Requirements
- R1: While the synchronised reset line is low, the count rises by exactly one per reference clock edge. A line held low across N rising edges adds N to the count. The new value becomes readable two edges after the last low sample.
- R2: The count saturates at 2^CNT_W-1 and holds that value while the line stays low. CNT_W defaults to 29.
- R3: While the line is high, the count holds steady. A later low period adds to the held value.
- R4: A read at address REG_ADDR (default 0x50) returns the count in bits CNT_W-1:0 and zero in every bit above. A read at any other address returns zero.
- R5: A write to REG_ADDR with wdata_i bit 31 set to 1 clears the count to zero at that clock edge. If an increment falls on the same edge, the clear wins.
- R6: A write to REG_ADDR with bit 31 equal to 0 leaves the count unchanged. So does a write with bit 31 set to 1 to any other address.
- R7: Asserting rst_ni clears the count to zero. Holding sys_rst_ni low never clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| sys_rst_ni | input | 1 | Asynchronous active-low reset line being measured |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data; bit 31 requests a clear |
| rdata_o | output | DATA_W | Read data, zero-extended count |

## Verification
The hardest case to reach from the ports is a software clear landing on the same edge as an increment. The stimulus holds the line low long enough for the synchroniser to pass the low level through. On the same falling edge, it issues the clear write and releases the line. The count then shows only the single increment still in the synchroniser pipe.

Saturation is reached by building the bench with a narrow counter. The stimulus then holds the line low far past the all-ones value.

// File: rtl/rhd_pkg.sv
package rhd_pkg;
  localparam int unsigned RHD_CNT_W       = 29;
  localparam int unsigned RHD_ADDR_W      = 8;
  localparam int unsigned RHD_DATA_W      = 32;
  localparam int unsigned RHD_REG_ADDR    = 32'h50;
  localparam int unsigned RHD_CLR_BIT     = 31;
  localparam int unsigned RHD_SYNC_STAGES = 2;
  localparam int unsigned RHD_TICKS_1S    = 25_000_000;
endpackage

// File: rtl/rhd_sync.sv
module rhd_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= {STAGES{RST_VAL}};
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= {STAGES{RST_VAL}};
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/rhd_sat_counter.sv
module rhd_sat_counter #(
  parameter int unsigned W = 29
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         sat_o
);
  localparam logic [W-1:0] CntMax = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;

  assign sat_o = (cnt_q == CntMax);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)               cnt_d = '0;   // clear beats increment
    else if (inc_i && !sat_o) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rhd_regif.sv
module rhd_regif #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 29,
  parameter int unsigned REG_ADDR = 32'h50,
  parameter int unsigned CLR_BIT  = 31
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PadW = DATA_W - CNT_W;

  logic hit;
  assign hit   = (addr_i == ADDR_W'(REG_ADDR));
  assign clr_o = hit && we_i && wdata_i[CLR_BIT];

  always_comb begin
    rdata_o = '0;
    if (hit) rdata_o = {{PadW{1'b0}}, cnt_i};
  end
endmodule

// File: rtl/rst_hold_meter.sv
module rst_hold_meter
  import rhd_pkg::*;
#(
  parameter int unsigned CNT_W       = RHD_CNT_W,
  parameter int unsigned ADDR_W      = RHD_ADDR_W,
  parameter int unsigned DATA_W      = RHD_DATA_W,
  parameter int unsigned REG_ADDR    = RHD_REG_ADDR,
  parameter int unsigned CLR_BIT     = RHD_CLR_BIT,
  parameter int unsigned SYNC_STAGES = RHD_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic             line_sync;
  logic             meas_low;
  logic             clr_hit;
  logic             cnt_sat;
  logic [CNT_W-1:0] cnt_q;

  rhd_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sys_rst_ni),
    .q_o   (line_sync)
  );

  assign meas_low = ~line_sync;

  rhd_sat_counter #(
    .W(CNT_W)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (meas_low),
    .clr_i (clr_hit),
    .cnt_o (cnt_q),
    .sat_o (cnt_sat)
  );

  rhd_regif #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .REG_ADDR(REG_ADDR),
    .CLR_BIT (CLR_BIT)
  ) u_regif (
    .addr_i (addr_i),
    .we_i   (we_i),
    .wdata_i(wdata_i),
    .cnt_i  (cnt_q),
    .clr_o  (clr_hit),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/rst_hold_meter_chk.sv
module rst_hold_meter_chk #(
  parameter int unsigned CNT_W  = 29,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              meas_low_i,
  input logic              clr_i,
  input logic [DATA_W-1:0] rdata_i
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_low_i && !clr_i && cnt_i != CntMax) |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  p_saturate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CntMax && !clr_i) |=> cnt_i == CntMax);

  p_hold_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!meas_low_i && !clr_i) |=> $stable(cnt_i));

  p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_i[DATA_W-1:CNT_W] == '0);

  p_clear_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_i == '0);
endmodule

bind rst_hold_meter rst_hold_meter_chk #(
  .CNT_W (CNT_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_i     (cnt_q),
  .meas_low_i(meas_low),
  .clr_i     (clr_hit),
  .rdata_i   (rdata_o)
);

// File: tb/rst_hold_meter_tb_top.sv
module rst_hold_meter_tb_top;
  localparam int unsigned CNT_W    = 6;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;
  localparam logic [7:0]  REG_A    = 8'h50;
  localparam logic [31:0] SAT_V    = 32'd63;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sys_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;

  int checks = 0;
  int errors = 0;
  bit rd_pend = 1'b0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  rst_hold_meter #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sys_rst_ni(sys_n),
    .addr_i    (addr),
    .we_i      (we),
    .wdata_i   (wdata),
    .rdata_o   (rdata)
  );

  // monitor: compare 1 ns after the edge following a read request
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rd_pend) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: got 0x%08h expected 0x%08h", t, rdata, e);
        end
        rd_pend = 1'b0;
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_pend = 1'b1;
    wait (rd_pend == 1'b0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  // line low across n rising edges, then let the synchroniser settle
  task automatic hold_low(input int n);
    @(negedge clk);
    sys_n = 1'b0;
    repeat (n) @(negedge clk);
    sys_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    rd(REG_A, 32'd0, "R7 reset value");
    hold_low(10);
    rd(REG_A, 32'd10, "R1 ten-edge hold");
    hold_low(1);
    rd(REG_A, 32'd11, "R1 single-edge pulse");
    hold_low(5);
    rd(REG_A, 32'd16, "R3 resume from held value");
    repeat (20) @(negedge clk);
    rd(REG_A, 32'd16, "R3 steady while high");
    wr(REG_A, 32'h7fff_ffff);
    rd(REG_A, 32'd16, "R6 write bit31=0 ignored");
    wr(8'h54, 32'h8000_0000);
    rd(REG_A, 32'd16, "R6 clear at other address ignored");
    rd(8'h54, 32'd0, "R4 other address reads zero");
    wr(REG_A, 32'h8000_0000);
    rd(REG_A, 32'd0, "R5 clear");
    hold_low(80);
    rd(REG_A, SAT_V, "R2 saturate, R4 upper bits zero");
    hold_low(5);
    rd(REG_A, SAT_V, "R2 stays saturated");

    // R5 clear and increment on the same edge
    wr(REG_A, 32'h8000_0000);
    @(negedge clk);
    sys_n = 1'b0;
    repeat (5) @(negedge clk);
    addr = REG_A; wdata = 32'h8000_0000; we = 1'b1; sys_n = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rd(REG_A, 32'd1, "R5 clear wins over increment");

    // R7 measured line does not clear; power-on reset does
    hold_low(4);
    rd(REG_A, 32'd5, "R7 count kept after measured reset");
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(REG_A, 32'd0, "R7 power-on reset clears");
    hold_low(3);
    rd(REG_A, 32'd3, "R1 count after power-on reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule